// File: doc/BRIEF.md
# Low-Bit Weight Unpacking Front End

This block sits in front of a signed 8-bit multiply-accumulate pipeline and turns packed, bit-plane-split quantized weights into plain signed small integers, so that the same back end can serve several compressed formats. Each input word carries `LANES` weights whose bits are stored in two separate planes. A per-word mode select picks how the planes are read.

In the 3-bit mode each lane joins a 2-bit low field and a 1-bit high field into a 3-bit code, recentred to the range -4..3. The 6-bit block scale that comes with the word is reduced to 5 bits by rounding half up and saturating, so that it fits the narrow scale path of the back end. In the 6-bit mode each lane joins a 4-bit low field and a 2-bit high field into a 6-bit code, recentred to -32..31. Each weight is then multiplied by the signed 8-bit scale to give a 16-bit intermediate value per lane. All decoding is combinational and lands in one output register stage. Modes may alternate from word to word with no bubble.

Top module: `lowbit_unpack`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `out_mode`, `out_wt`, `out_prod` and `out_scale` are all zero.
- R2: `out_valid` in each cycle equals `in_valid` of the previous cycle (one register stage, no bubble, no stall).
- R3: With `in_mode`=0, lane i of `out_wt` (bits 8i+7..8i) is the signed value `4*in_word[2*LANES+i] + in_word[2i+1:2i] - 4`, sign-extended to 8 bits.
- R4: With `in_mode`=0, `out_scale` is `min(31, (s+1)>>1)` where s is `in_scale[5:0]`; bits 7..5 of `out_scale` are zero and `in_scale[7:6]` has no effect.
- R5: With `in_mode`=0, bits of `in_word` at position 3*LANES and above have no effect on any output, and `out_prod` is all zero.
- R6: With `in_mode`=1, lane i of `out_wt` is the signed value `16*in_word[4*LANES+2i+1:4*LANES+2i] + in_word[4i+3:4i] - 32`, sign-extended to 8 bits.
- R7: With `in_mode`=1, lane i of `out_prod` (bits 16i+15..16i) is the lane-i weight of R6 times `in_scale` read as a signed 8-bit number, as a 16-bit two's-complement value, and `out_scale` equals `in_scale`.
- R8: `out_mode` is the `in_mode` accepted with the word; words of either mode may follow each other in consecutive cycles and each is decoded in its own mode.
- R9: In a cycle after `in_valid` was low, `out_wt`, `out_prod`, `out_scale` and `out_mode` keep the values they held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_mode | input | 1 | 0: 3-bit weights with 5-bit scale; 1: 6-bit weights with 16-bit products |
| in_word | input | 6*LANES | Packed weight planes |
| in_scale | input | 8 | Block scale (6-bit unsigned in mode 0, signed 8-bit in mode 1) |
| out_valid | output | 1 | Output word present |
| out_mode | output | 1 | Mode of the output word |
| out_wt | output | 8*LANES | Signed 8-bit weights, one byte per lane |
| out_prod | output | 16*LANES | Signed weight-times-scale per lane (mode 1) |
| out_scale | output | 8 | Reduced scale (mode 0) or passed scale (mode 1) |

## Verification
The 3-bit mode is swept over every combination of the twelve used weight bits with noise in the unused upper bits, which separates swapped planes, swapped lanes and a wrong recentring offset, and shows the unused bits are ignored. The scale reduction is swept over all 64 codes with the top two scale bits set, which pins down the rounding direction and the saturation at 63. The 6-bit mode pairs every 6-bit code in each lane with every signed scale, exposing sign-extension and product-width errors, and a stretch of alternating modes with idle gaps shows per-word mode selection and output holding.

// File: rtl/lowbit_unpack.sv
module lowbit_unpack #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_mode,
  input  logic [6*LANES-1:0]    in_word,
  input  logic [7:0]            in_scale,
  output logic                  out_valid,
  output logic                  out_mode,
  output logic [8*LANES-1:0]    out_wt,
  output logic [16*LANES-1:0]   out_prod,
  output logic [7:0]            out_scale
);
  localparam int HI3 = 2*LANES;
  localparam int HI6 = 4*LANES;

  logic [8*LANES-1:0]  wt_d;
  logic [16*LANES-1:0] prod_d;
  logic [7:0]          scale_d;
  logic [6:0]          rnd;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [2:0]        code3;
    logic [5:0]        code6;
    logic signed [7:0] w3, w6;
    logic signed [15:0] p6;
    assign code3 = {in_word[HI3+i], in_word[2*i+1 -: 2]};
    assign code6 = {in_word[HI6+2*i+1 -: 2], in_word[4*i+3 -: 4]};
    assign w3 = $signed({5'd0, code3}) - 8'sd4;
    assign w6 = $signed({2'd0, code6}) - 8'sd32;
    assign p6 = w6 * $signed(in_scale);
    assign wt_d[8*i +: 8]    = in_mode ? w6 : w3;
    assign prod_d[16*i +: 16] = in_mode ? p6 : 16'd0;
  end

  assign rnd     = {1'b0, in_scale[5:0]} + 7'd1;
  assign scale_d = in_mode ? in_scale : (rnd[6] ? 8'd31 : {3'd0, rnd[5:1]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_wt    <= '0;
      out_prod  <= '0;
      out_scale <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mode  <= in_mode;
        out_wt    <= wt_d;
        out_prod  <= prod_d;
        out_scale <= scale_d;
      end
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_mode_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_mode == $past(in_mode));
  assert_scale_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mode) |-> out_scale <= 8'd31);
  assert_prod_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mode) |-> out_prod == '0);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_wt) && $stable(out_prod) && $stable(out_scale) && $stable(out_mode));
endmodule

// File: tb/sim_lowbit_unpack.sv
module sim_lowbit_unpack;
  localparam int LANES = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 6*LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_mode = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic [7:0] in_scale = '0;
  logic out_valid, out_mode;
  logic [8*LANES-1:0] out_wt;
  logic [16*LANES-1:0] out_prod;
  logic [7:0] out_scale;

  int total = 0;
  int bad = 0;
  bit done = 0;

  lowbit_unpack #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_word(in_word), .in_scale(in_scale), .out_valid(out_valid),
    .out_mode(out_mode), .out_wt(out_wt), .out_prod(out_prod), .out_scale(out_scale)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8*LANES-1:0] exp_wt(input logic m, input logic [WW-1:0] w);
    logic [8*LANES-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int v;
      if (!m) v = 4*int'(w[2*LANES+i]) + int'((w >> (2*i)) & 3) - 4;
      else    v = 16*int'((w >> (4*LANES+2*i)) & 3) + int'((w >> (4*i)) & 15) - 32;
      r[8*i +: 8] = 8'(v);
    end
    return r;
  endfunction

  function automatic logic [16*LANES-1:0] exp_prod(input logic m, input logic [WW-1:0] w, input logic [7:0] s);
    logic [16*LANES-1:0] r;
    int sc;
    sc = (s >= 128) ? int'(s) - 256 : int'(s);
    for (int i = 0; i < LANES; i++) begin
      int v;
      v = 16*int'((w >> (4*LANES+2*i)) & 3) + int'((w >> (4*i)) & 15) - 32;
      r[16*i +: 16] = m ? 16'(v*sc) : 16'd0;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_scale(input logic m, input logic [7:0] s);
    int v;
    if (m) return s;
    v = (int'(s & 8'h3f) + 1) / 2;
    if (v > 31) v = 31;
    return 8'(v);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic m, input logic [WW-1:0] w, input logic [7:0] s);
    @(negedge clk);
    in_valid = v; in_mode = m; in_word = w; in_scale = s;
    @(posedge clk); #1;
  endtask

  task automatic full_check(input string req, input logic m, input logic [WW-1:0] w, input logic [7:0] s);
    logic [127:0] a, e;
    a = {out_valid, out_mode, out_scale, out_wt, out_prod};
    e = {1'b1, m, exp_scale(m, s), exp_wt(m, w), exp_prod(m, w, s)};
    check(req, a, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {out_valid, out_mode, out_scale, out_wt, out_prod}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", {out_valid, out_mode, out_scale, out_wt, out_prod}, '0);

    // R3 R5: every used 3-bit-mode bit combination, noise in unused upper bits
    for (int k = 0; k < (1 << (3*LANES)); k++) begin
      logic [WW-1:0] w;
      w = WW'(k) | (WW'((k * 37) & 'hfff) << (3*LANES));
      drive(1'b1, 1'b0, w, 8'h15);
      full_check("R3/R5 3-bit weights", 1'b0, w, 8'h15);
    end

    // R4: all 6-bit scale codes, upper bits set
    for (int s = 0; s < 64; s++) begin
      drive(1'b1, 1'b0, WW'(s * 91), 8'(s) | 8'hc0);
      check("R4 scale reduce", out_scale, exp_scale(1'b0, 8'(s)));
    end

    // R6 R7: every 6-bit code per lane against every signed scale
    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < 256; s += 1) begin
        logic [WW-1:0] w;
        w = '0;
        for (int i = 0; i < LANES; i++) begin
          int code;
          code = (c + 17*i) % 64;
          w[4*i +: 4] = 4'(code & 15);
          w[4*LANES+2*i +: 2] = 2'(code >> 4);
        end
        drive(1'b1, 1'b1, w, 8'(s));
        full_check("R6/R7 6-bit products", 1'b1, w, 8'(s));
      end
    end

    // R2 R8 R9: alternating modes back to back with idle gaps
    for (int k = 0; k < 40; k++) begin
      logic [WW-1:0] w;
      logic m;
      logic [7:0] s;
      w = WW'(k * 40503 + 7);
      m = k[0];
      s = 8'(k * 29 + 3);
      drive(1'b1, m, w, s);
      full_check("R8 mode per word", m, w, s);
      if (k % 3 == 2) begin
        drive(1'b0, ~m, ~w, ~s);
        check("R2 valid drops", out_valid, 1'b0);
        check("R9 hold", {out_mode, out_scale, out_wt, out_prod},
              {m, exp_scale(m, s), exp_wt(m, w), exp_prod(m, w, s)});
      end
    end
    drive(1'b0, 1'b0, '0, '0);
    check("R2 idle", out_valid, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule